// File: doc/BRIEF.md
# Waveform Pattern Timing Sequencer

This block generates the timing skeleton for a pattern-playback DAC engine. A falling edge on an active-low trigger starts a sequence. An optional start delay comes first, and its unit length is set by its own 4-bit prescaler. A pattern period follows, with its unit length set by a second, independent 4-bit prescaler. The period plays a programmed number of times, back to back. While a period plays, a sample-advance strobe tells the downstream sample source when to step. Each sample is held for a programmed number of DAC clock slots.

The block has three states. IDLE waits for a trigger edge. DELAY counts the prescaled start delay. PLAY counts prescaled period units, hold slots and completed repetitions. The named transitions are as follows:
- IDLE->DELAY (trigger edge with a nonzero delay)
- IDLE->PLAY (trigger edge with a zero delay)
- DELAY->PLAY (delay exhausted)
- PLAY->PLAY (a period ends and repetitions remain; the counters restart)
- PLAY->IDLE (the last period ends; done is set)

Configuration is taken from plain register inputs and must be held stable while a sequence runs.

Top module: `pattern_sequencer`

## Requirements
- R1: After reset, `sample_adv`, `pat_active`, `pat_end` and `done` are all 0, and the block waits in IDLE.
- R2: A sequence starts only on a high-to-low transition of `trig_n` seen while the block is idle (with `done` either 0 or 1). Holding `trig_n` low does not start another sequence.
- R3: The start delay lasts `cfg_delay * (cfg_dly_pre + 1)` clock cycles, measured from the cycle after the trigger edge. With `cfg_delay = 0`, `pat_active` is 1 in the first cycle after the edge.
- R4: Each period lasts `P * (cfg_per_pre + 1)` cycles. P is `cfg_period`, except that a value of 0 counts as 1.
- R5: Exactly `cfg_repeat + 1` periods play, back to back. `pat_active` stays 1 for their full combined length.
- R6: `pat_end` is 1 only in the last cycle of each period, which gives exactly one pulse per period.
- R7: `sample_adv` is 1 in the first cycle of each period and every `cfg_hold + 1` cycles after that within the period. It is never 1 while `pat_active` is 0.
- R8: `done` goes to 1 in the cycle after the last period ends. It stays 1 until the next trigger edge, which clears it, and it is never 1 together with `pat_active`.
- R9: Trigger edges that arrive during the delay or during playback have no effect on the sequence timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DAC clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_n | input | 1 | Active-low trigger; the falling edge starts a sequence |
| cfg_hold | input | 4 | Sample hold count minus one |
| cfg_per_pre | input | 4 | Period prescale: clocks per period unit minus one |
| cfg_dly_pre | input | 4 | Delay prescale: clocks per delay unit minus one |
| cfg_period | input | 16 | Pattern period in prescaled units (0 acts as 1) |
| cfg_delay | input | 16 | Start delay in prescaled units |
| cfg_repeat | input | 8 | Number of periods minus one |
| sample_adv | output | 1 | Sample-advance strobe |
| pat_active | output | 1 | High while a pattern period plays |
| pat_end | output | 1 | Pulse in the last cycle of each period |
| done | output | 1 | Sticky flag set after the final period |

## Verification
Two outputs can fall in the same cycle: the `sample_adv` strobe that opens a hold slot and the `pat_end` pulse that closes a period. This happens whenever the period length in clocks is one more than a multiple of `cfg_hold + 1`, and on every cycle when `cfg_hold` is 0. The vector table includes such settings, including a one-clock period. In every one of them the bench counts strobes and end pulses separately, so a design that drops or merges either event when they coincide shows up as a miscount against the closed-form totals.

// File: rtl/pattern_seq_pkg.sv
package pattern_seq_pkg;
    localparam int PRE_W = 4;
    localparam int LEN_W = 16;
    localparam int REP_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DELAY = 2'd1,
        ST_PLAY  = 2'd2
    } seq_state_t;
endpackage

// File: rtl/trig_edge_detect.sv
module trig_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_n,
    output logic fall
);
    logic trig_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trig_q <= 1'b1;
        else        trig_q <= trig_n;
    end

    assign fall = trig_q & ~trig_n;
endmodule

// File: rtl/unit_scaler.sv
module unit_scaler #(
    parameter int PRE_W = 4,
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic [PRE_W-1:0] pre,
    input  logic [LEN_W-1:0] limit,
    output logic             last
);
    logic [PRE_W-1:0] pre_cnt;
    logic [LEN_W-1:0] unit_cnt;
    logic             pre_wrap;

    assign pre_wrap = (pre_cnt == pre);
    assign last     = run && pre_wrap && (unit_cnt == limit - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_cnt  <= '0;
            unit_cnt <= '0;
        end else if (clear || last) begin
            pre_cnt  <= '0;
            unit_cnt <= '0;
        end else if (run) begin
            if (pre_wrap) begin
                pre_cnt  <= '0;
                unit_cnt <= unit_cnt + 1'b1;
            end else begin
                pre_cnt <= pre_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/hold_slot_counter.sv
module hold_slot_counter #(
    parameter int HOLD_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              run,
    input  logic [HOLD_W-1:0] hold,
    output logic              slot_start
);
    logic [HOLD_W-1:0] slot_cnt;

    assign slot_start = run && (slot_cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   slot_cnt <= '0;
        else if (clear)               slot_cnt <= '0;
        else if (run) begin
            if (slot_cnt == hold)     slot_cnt <= '0;
            else                      slot_cnt <= slot_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pattern_sequencer.sv
module pattern_sequencer
    import pattern_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_n,
    input  logic [PRE_W-1:0] cfg_hold,
    input  logic [PRE_W-1:0] cfg_per_pre,
    input  logic [PRE_W-1:0] cfg_dly_pre,
    input  logic [LEN_W-1:0] cfg_period,
    input  logic [LEN_W-1:0] cfg_delay,
    input  logic [REP_W-1:0] cfg_repeat,
    output logic             sample_adv,
    output logic             pat_active,
    output logic             pat_end,
    output logic             done
);
    seq_state_t       state_q, state_d;
    logic             trig_fall;
    logic             dly_last, per_last, slot_start;
    logic             in_delay, in_play, last_rep;
    logic [REP_W-1:0] rep_q;
    logic [LEN_W-1:0] per_limit;
    logic             done_q;

    assign in_delay  = (state_q == ST_DELAY);
    assign in_play   = (state_q == ST_PLAY);
    assign last_rep  = (rep_q == cfg_repeat);
    assign per_limit = (cfg_period == '0) ? LEN_W'(1) : cfg_period;

    trig_edge_detect u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .trig_n (trig_n),
        .fall   (trig_fall)
    );

    unit_scaler #(.PRE_W(PRE_W), .LEN_W(LEN_W)) u_delay_scaler (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (!in_delay),
        .run   (in_delay),
        .pre   (cfg_dly_pre),
        .limit (cfg_delay),
        .last  (dly_last)
    );

    unit_scaler #(.PRE_W(PRE_W), .LEN_W(LEN_W)) u_period_scaler (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (!in_play),
        .run   (in_play),
        .pre   (cfg_per_pre),
        .limit (per_limit),
        .last  (per_last)
    );

    hold_slot_counter #(.HOLD_W(PRE_W)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (!in_play || per_last),
        .run        (in_play),
        .hold       (cfg_hold),
        .slot_start (slot_start)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (trig_fall)
                    state_d = (cfg_delay == '0) ? ST_PLAY : ST_DELAY;
            end
            ST_DELAY: begin
                if (dly_last) state_d = ST_PLAY;
            end
            ST_PLAY: begin
                if (per_last && last_rep) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Repetition counter and sticky completion flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rep_q  <= '0;
            done_q <= 1'b0;
        end else begin
            if (!in_play)      rep_q <= '0;
            else if (per_last) rep_q <= rep_q + 1'b1;

            if (in_play && per_last && last_rep)
                done_q <= 1'b1;
            else if (state_q == ST_IDLE && trig_fall)
                done_q <= 1'b0;
        end
    end

    // Output logic
    always_comb begin
        sample_adv = 1'b0;
        pat_active = 1'b0;
        pat_end    = 1'b0;
        unique case (state_q)
            ST_PLAY: begin
                pat_active = 1'b1;
                sample_adv = slot_start;
                pat_end    = per_last;
            end
            default: ;
        endcase
        done = done_q;
    end
endmodule

// File: rtl/pattern_sequencer_checker.sv
module pattern_sequencer_checker (
    input logic clk,
    input logic rst_n,
    input logic trig_n,
    input logic sample_adv,
    input logic pat_active,
    input logic pat_end,
    input logic done
);
    assert_adv_in_play_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sample_adv |-> pat_active);

    assert_first_adv_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pat_active) |-> sample_adv);

    assert_end_in_play_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pat_end |-> pat_active);

    assert_stop_after_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pat_active) |-> $past(pat_end));

    assert_stop_sets_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pat_active) |-> done);

    assert_done_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !pat_active);

    assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && trig_n) |=> done);
endmodule

bind pattern_sequencer pattern_sequencer_checker u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig_n     (trig_n),
    .sample_adv (sample_adv),
    .pat_active (pat_active),
    .pat_end    (pat_end),
    .done       (done)
);

// File: tb/pattern_sequencer_test.sv
module pattern_sequencer_test;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 6;
    // hold, per_pre, dly_pre, period, delay, repeat, exp_delay, exp_active, exp_adv, exp_end
    localparam int VEC [NVEC][10] = '{
        '{0, 0, 0, 4, 0, 0,  0,  4,  4, 1},
        '{1, 0, 0, 6, 2, 1,  2, 12,  6, 2},
        '{2, 1, 2, 3, 3, 2,  9, 18,  6, 3},
        '{3, 0, 1, 5, 1, 0,  2,  5,  2, 1},
        '{0, 2, 0, 2, 5, 3,  5, 24, 24, 4},
        '{0, 0, 0, 0, 0, 2,  0,  3,  3, 3}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trig_n = 1'b1;
    logic [3:0]  cfg_hold = '0, cfg_per_pre = '0, cfg_dly_pre = '0;
    logic [15:0] cfg_period = 16'd4, cfg_delay = '0;
    logic [7:0]  cfg_repeat = '0;
    logic        sample_adv, pat_active, pat_end, done;

    int checks = 0;
    int failures = 0;
    int m_delay, m_active, m_adv, m_end;

    always #(CLK_PERIOD/2) clk = ~clk;

    pattern_sequencer uut (
        .clk(clk), .rst_n(rst_n), .trig_n(trig_n),
        .cfg_hold(cfg_hold), .cfg_per_pre(cfg_per_pre), .cfg_dly_pre(cfg_dly_pre),
        .cfg_period(cfg_period), .cfg_delay(cfg_delay), .cfg_repeat(cfg_repeat),
        .sample_adv(sample_adv), .pat_active(pat_active), .pat_end(pat_end), .done(done)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Drive a trigger edge, then measure one sequence; retrig_at >= 0 injects a
    // second edge that many sampled cycles after the first (R9).
    task automatic run_seq(input int retrig_at);
        int cyc;
        bit seen;
        m_delay = 0; m_active = 0; m_adv = 0; m_end = 0;
        seen = 0;
        @(negedge clk) trig_n = 1'b0;
        @(negedge clk) trig_n = 1'b1;
        cyc = 0;
        while (!done && cyc < 2000) begin
            if (cyc == retrig_at)     trig_n = 1'b0;
            if (cyc == retrig_at + 1) trig_n = 1'b1;
            if (pat_active) seen = 1;
            if (!seen) m_delay++;
            if (pat_active) m_active++;
            if (sample_adv) m_adv++;
            if (pat_end) m_end++;
            if (sample_adv && !pat_active) check("R7", "strobe outside play", 1, 0);
            @(negedge clk);
            cyc++;
        end
        trig_n = 1'b1;
    endtask

    task automatic apply(input int v);
        cfg_hold    = 4'(VEC[v][0]);
        cfg_per_pre = 4'(VEC[v][1]);
        cfg_dly_pre = 4'(VEC[v][2]);
        cfg_period  = 16'(VEC[v][3]);
        cfg_delay   = 16'(VEC[v][4]);
        cfg_repeat  = 8'(VEC[v][5]);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "outputs in reset", {sample_adv, pat_active, pat_end, done}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1", "outputs after reset", {sample_adv, pat_active, pat_end, done}, 0);

        // Vector table walk: R3 delay, R4/R5 active length, R7 strobes, R6 ends, R8 done
        for (int v = 0; v < NVEC; v++) begin
            apply(v);
            run_seq(-10);
            check("R3", $sformatf("delay v%0d", v), m_delay, VEC[v][6]);
            check("R4_R5", $sformatf("active cycles v%0d", v), m_active, VEC[v][7]);
            check("R7", $sformatf("strobes v%0d", v), m_adv, VEC[v][8]);
            check("R6", $sformatf("end pulses v%0d", v), m_end, VEC[v][9]);
            check("R8", $sformatf("done v%0d", v), done, 1);
            repeat (3) @(negedge clk);
            check("R8", $sformatf("done sticky v%0d", v), done, 1);
        end

        // R9: retrigger during delay and during playback ignored (vector 2)
        apply(2);
        run_seq(4);
        check("R9", "retrig in delay: delay", m_delay, 9);
        check("R9", "retrig in delay: active", m_active, 18);
        apply(2);
        run_seq(15);
        check("R9", "retrig in play: active", m_active, 18);
        check("R9", "retrig in play: ends", m_end, 3);

        // R8: the trigger edge clears done; R2: a held-low level starts nothing more
        apply(0);
        @(negedge clk) trig_n = 1'b0;
        @(negedge clk);
        check("R8", "done cleared by edge", done, 0);
        check("R3", "zero delay active next cycle", pat_active, 1);
        repeat (10) @(negedge clk);
        check("R2", "done after held-low run", done, 1);
        check("R2", "held low no restart", pat_active, 0);
        repeat (5) @(negedge clk);
        check("R2", "still idle while low", pat_active, 0);
        trig_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R2", "rising edge no start", pat_active, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule